// File: doc/BRIEF.md
# Eight-bit accumulator ALU with decimal and split-result operations

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each request presents the accumulator byte, a second operand byte, the B register byte, the incoming carry and auxiliary carry, and a four-bit operation code. The unit returns a primary result byte for the accumulator and a secondary result byte. The secondary byte carries the high product, the remainder, or the other operand after a low-nibble exchange. It also returns parity, overflow, auxiliary carry and carry, each with its own write strobe, so the surrounding datapath knows which status bits to commit.

Most operations complete on the clock edge that accepts them. Multiply and divide run iteratively in a shared shift/add/subtract engine that retires `BITS_PER_STEP` bits per cycle. During that time `busy_o` is high and new requests are refused. A one-cycle `done_o` pulse marks every completion, and all write strobes are valid only in that cycle. Results and flags are registered and hold their values between completions.

Top module: `acc_alu`

## Requirements
- R1: A request is accepted on a rising edge when `start_i` is high and `busy_o` is low. The `op_i` codes are: 0 add, 1 add with carry, 2 subtract with borrow, 3 AND, 4 OR, 5 XOR, 6 rotate left, 7 rotate right, 8 rotate left through carry, 9 rotate right through carry, 10 nibble swap, 11 low-nibble exchange, 12 decimal adjust, 13 multiply, 14 divide and 15 no operation. Add gives `res_o` = low byte of `acc_i + opd_i` (plus `cy_i` for code 1 only). It sets carry from bit 7, auxiliary carry from bit 3 and overflow on signed two's complement overflow, and it writes all four flags.
- R2: Subtract with borrow gives `res_o` = `acc_i - opd_i - cy_i`. Carry is the borrow out of bit 7, auxiliary carry is the borrow out of bit 3, and overflow flags a signed result outside -128..127. All four flags are written.
- R3: AND, OR and XOR combine `acc_i` with `opd_i` and write only the parity flag.
- R4: Whenever parity is written, `par_o` is 1 exactly when the new `res_o` holds an odd number of ones.
- R5: Plain rotates move bit 7 into bit 0 (left) or bit 0 into bit 7 (right) and write no flag. Rotates through carry shift `cy_i` into the vacated bit and the bit shifted out into carry, and they write carry and parity.
- R6: Nibble swap exchanges bits 7:4 and 3:0 of `acc_i` and writes no flag. Low-nibble exchange returns `{acc_i[7:4], opd_i[3:0]}` on `res_o` and `{opd_i[7:4], acc_i[3:0]}` on `aux_o`, and it writes `aux_we_o` and parity.
- R7: Decimal adjust first adds 0x06 when `acc_i[3:0]` > 9 or `ac_i` is set. It then adds 0x60 when carry-in is set, when that first addition carried out of bit 7, or when the high nibble of the partial value is above 9. Carry is set exactly when the 0x60 correction is applied. Carry and parity are written.
- R8: Multiply places the 16-bit product `acc_i * breg_i` with its low byte on `res_o` and its high byte on `aux_o`. It clears carry, sets overflow when the product exceeds 255, and writes parity, overflow, carry and `aux_we_o`.
- R9: Divide places the quotient `acc_i / breg_i` on `res_o` and the remainder on `aux_o`. It clears carry and writes parity, overflow, carry and `aux_we_o`. Overflow is 0 for a nonzero divisor. For a zero divisor overflow is 1 and the result bytes and parity are undefined.
- R10: A single-cycle operation raises `done_o` in the cycle after its accepting edge. Multiply and divide hold `busy_o` high for `8/BITS_PER_STEP - 1` cycles and raise `done_o` in the cycle after the `8/BITS_PER_STEP`-th edge counted from acceptance. `done_o` is never high while `busy_o` is high.
- R11: A request presented while `busy_o` is high is ignored and does not disturb the running operation. A no-operation request raises `done_o` and changes no output value.
- R12: While reset is low, all outputs are 0.
- R13: The write strobes and `aux_we_o` are high only in a `done_o` cycle. `res_o`, `aux_o` and each flag hold their values until they are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request valid |
| op_i | input | 4 | Operation code (see R1) |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Second operand |
| breg_i | input | 8 | B register operand for multiply and divide |
| cy_i | input | 1 | Carry in |
| ac_i | input | 1 | Auxiliary carry in (decimal adjust) |
| res_o | output | 8 | Primary result |
| aux_o | output | 8 | Secondary result |
| par_o | output | 1 | Parity flag |
| ov_o | output | 1 | Overflow flag |
| ac_o | output | 1 | Auxiliary carry flag |
| cy_o | output | 1 | Carry flag |
| par_we_o | output | 1 | Parity write strobe |
| ov_we_o | output | 1 | Overflow write strobe |
| ac_we_o | output | 1 | Auxiliary carry write strobe |
| cy_we_o | output | 1 | Carry write strobe |
| aux_we_o | output | 1 | Secondary result write strobe |
| busy_o | output | 1 | Multiply or divide in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The bench builds the unit with `BITS_PER_STEP` = 2, so multiply and divide take four cycles. That leaves three busy cycles in which back-to-back and overlapping requests can be offered and shown to be refused. Directed cases cover the signed overflow and nibble-carry corners of add and subtract, every decimal-adjust branch, products above and below 255, and division by zero. A long random stream with idle gaps then mixes all sixteen codes against the behavioural model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int unsigned DW  = 8;
    localparam int unsigned NIB = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_RL   = 4'd6,
        OP_RR   = 4'd7,
        OP_RLC  = 4'd8,
        OP_RRC  = 4'd9,
        OP_SWAP = 4'd10,
        OP_XCHD = 4'd11,
        OP_DA   = 4'd12,
        OP_MUL  = 4'd13,
        OP_DIV  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic par;
        logic ov;
        logic ac;
        logic cy;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] aux;
        flags_t        fl;
        flags_t        fl_we;
        logic          res_we;
        logic          aux_we;
    } alu_out_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] aux;
        flags_t        fl;
        flags_t        fl_we;
        logic          aux_we;
        logic          done;
    } acc_state_t;

endpackage

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    localparam logic [DW:0]   LO_FIX = (DW+1)'(6);
    localparam logic [DW-1:0] HI_FIX = DW'(6) << NIB;

    logic          lo_need;
    logic          hi_need;
    logic [DW:0]   part;

    always_comb begin
        lo_need = ac_i || (a_i[NIB-1:0] > NIB'(9));
        part    = {1'b0, a_i} + (lo_need ? LO_FIX : '0);
        hi_need = cy_i || part[DW] || (part[DW-1:NIB] > NIB'(9));
        res_o   = part[DW-1:0] + (hi_need ? HI_FIX : '0);
        cy_o    = hi_need;
    end

endmodule

// File: rtl/acc_alu_ops.sv
module acc_alu_ops
    import acc_alu_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output alu_out_t      out_o
);
    logic          cin;
    logic [DW:0]   add_w;
    logic [NIB:0]  add_n;
    logic [DW:0]   sub_w;
    logic [NIB:0]  sub_n;
    logic [DW-1:0] da_res;
    logic          da_cy;

    assign cin   = (op_i == OP_ADDC) ? cy_i : 1'b0;
    assign add_w = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
    assign add_n = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin};
    assign sub_w = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cy_i};
    assign sub_n = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cy_i};

    acc_alu_decadj u_decadj (
        .a_i   (a_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    always_comb begin
        out_o        = '0;
        out_o.res_we = 1'b1;
        unique case (op_i)
            OP_ADD, OP_ADDC: begin
                out_o.res   = add_w[DW-1:0];
                out_o.fl.cy = add_w[DW];
                out_o.fl.ac = add_n[NIB];
                out_o.fl.ov = (a_i[DW-1] == b_i[DW-1]) && (add_w[DW-1] != a_i[DW-1]);
                out_o.fl_we = 4'b1111;
            end
            OP_SUBB: begin
                out_o.res   = sub_w[DW-1:0];
                out_o.fl.cy = sub_w[DW];
                out_o.fl.ac = sub_n[NIB];
                out_o.fl.ov = (a_i[DW-1] != b_i[DW-1]) && (sub_w[DW-1] != a_i[DW-1]);
                out_o.fl_we = 4'b1111;
            end
            OP_AND: begin
                out_o.res   = a_i & b_i;
                out_o.fl_we = 4'b1000;
            end
            OP_OR: begin
                out_o.res   = a_i | b_i;
                out_o.fl_we = 4'b1000;
            end
            OP_XOR: begin
                out_o.res   = a_i ^ b_i;
                out_o.fl_we = 4'b1000;
            end
            OP_RL:  out_o.res = {a_i[DW-2:0], a_i[DW-1]};
            OP_RR:  out_o.res = {a_i[0], a_i[DW-1:1]};
            OP_RLC: begin
                out_o.res   = {a_i[DW-2:0], cy_i};
                out_o.fl.cy = a_i[DW-1];
                out_o.fl_we = 4'b1001;
            end
            OP_RRC: begin
                out_o.res   = {cy_i, a_i[DW-1:1]};
                out_o.fl.cy = a_i[0];
                out_o.fl_we = 4'b1001;
            end
            OP_SWAP: out_o.res = {a_i[NIB-1:0], a_i[DW-1:NIB]};
            OP_XCHD: begin
                out_o.res    = {a_i[DW-1:NIB], b_i[NIB-1:0]};
                out_o.aux    = {b_i[DW-1:NIB], a_i[NIB-1:0]};
                out_o.aux_we = 1'b1;
                out_o.fl_we  = 4'b1000;
            end
            OP_DA: begin
                out_o.res   = da_res;
                out_o.fl.cy = da_cy;
                out_o.fl_we = 4'b1001;
            end
            default: out_o.res_we = 1'b0;
        endcase
        out_o.fl.par = ^out_o.res;
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
    import acc_alu_pkg::*;
#(
    parameter int unsigned BITS_PER_STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          div_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          busy_o,
    output logic          last_o,
    output logic [DW-1:0] res_o,
    output logic [DW-1:0] aux_o,
    output logic          ov_o
);
    localparam int unsigned STEPS = DW / BITS_PER_STEP;
    localparam int unsigned CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] dv;
        logic          is_div;
        logic [CW-1:0] cnt;
        logic          busy;
    } md_state_t;

    md_state_t     d, q;
    logic [DW-1:0] hi, lo, dv;
    logic          dvs;
    logic          run;
    logic [DW:0]   tmp;

    always_comb begin
        d   = q;
        tmp = '0;
        hi  = go_i ? '0   : q.hi;
        lo  = go_i ? a_i  : q.lo;
        dv  = go_i ? b_i  : q.dv;
        dvs = go_i ? div_i : q.is_div;
        for (int k = 0; k < int'(BITS_PER_STEP); k++) begin
            if (dvs) begin
                tmp = {hi, lo[DW-1]};
                lo  = {lo[DW-2:0], 1'b0};
                if (tmp >= {1'b0, dv}) begin
                    tmp   = tmp - {1'b0, dv};
                    lo[0] = 1'b1;
                end
                hi = tmp[DW-1:0];
            end else begin
                tmp = {1'b0, hi} + (lo[0] ? {1'b0, dv} : '0);
                lo  = {tmp[0], lo[DW-1:1]};
                hi  = tmp[DW:1];
            end
        end
        run = go_i || q.busy;
        if (go_i) begin
            d.cnt    = CW'(STEPS - 1);
            d.busy   = (STEPS > 1) ? 1'b1 : 1'b0;
            d.is_div = div_i;
            d.dv     = b_i;
        end else if (q.busy) begin
            d.cnt  = q.cnt - CW'(1);
            d.busy = (q.cnt != CW'(1));
        end
        if (run) begin
            d.hi = hi;
            d.lo = lo;
        end
        last_o = run && (go_i ? (STEPS == 1) : (q.cnt == CW'(1)));
        res_o  = lo;
        aux_o  = hi;
        ov_o   = dvs ? (dv == '0) : (hi != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int unsigned BITS_PER_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [3:0] op_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opd_i,
    input  logic [7:0] breg_i,
    input  logic       cy_i,
    input  logic       ac_i,
    output logic [7:0] res_o,
    output logic [7:0] aux_o,
    output logic       par_o,
    output logic       ov_o,
    output logic       ac_o,
    output logic       cy_o,
    output logic       par_we_o,
    output logic       ov_we_o,
    output logic       ac_we_o,
    output logic       cy_we_o,
    output logic       aux_we_o,
    output logic       busy_o,
    output logic       done_o
);
    acc_state_t    d, q;
    alu_op_e       op_e;
    alu_out_t      ops;
    logic          md_busy, md_last, md_ov;
    logic [DW-1:0] md_res, md_aux;
    logic          accept, is_md;

    assign op_e   = alu_op_e'(op_i);
    assign accept = start_i && !md_busy;
    assign is_md  = (op_e == OP_MUL) || (op_e == OP_DIV);

    acc_alu_ops u_ops (
        .op_i  (op_e),
        .a_i   (acc_i),
        .b_i   (opd_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .out_o (ops)
    );

    acc_alu_muldiv #(.BITS_PER_STEP(BITS_PER_STEP)) u_muldiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (accept && is_md),
        .div_i  (op_e == OP_DIV),
        .a_i    (acc_i),
        .b_i    (breg_i),
        .busy_o (md_busy),
        .last_o (md_last),
        .res_o  (md_res),
        .aux_o  (md_aux),
        .ov_o   (md_ov)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.fl_we  = '0;
        d.aux_we = 1'b0;
        if (md_last) begin
            d.res    = md_res;
            d.aux    = md_aux;
            d.fl.par = ^md_res;
            d.fl.ov  = md_ov;
            d.fl.cy  = 1'b0;
            d.fl_we  = 4'b1101;
            d.aux_we = 1'b1;
            d.done   = 1'b1;
        end else if (accept && !is_md) begin
            d.done   = 1'b1;
            d.fl_we  = ops.fl_we;
            d.aux_we = ops.aux_we;
            if (ops.res_we)     d.res    = ops.res;
            if (ops.aux_we)     d.aux    = ops.aux;
            if (ops.fl_we.par)  d.fl.par = ops.fl.par;
            if (ops.fl_we.ov)   d.fl.ov  = ops.fl.ov;
            if (ops.fl_we.ac)   d.fl.ac  = ops.fl.ac;
            if (ops.fl_we.cy)   d.fl.cy  = ops.fl.cy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_o    = q.res;
    assign aux_o    = q.aux;
    assign par_o    = q.fl.par;
    assign ov_o     = q.fl.ov;
    assign ac_o     = q.fl.ac;
    assign cy_o     = q.fl.cy;
    assign par_we_o = q.fl_we.par;
    assign ov_we_o  = q.fl_we.ov;
    assign ac_we_o  = q.fl_we.ac;
    assign cy_we_o  = q.fl_we.cy;
    assign aux_we_o = q.aux_we;
    assign done_o   = q.done;
    assign busy_o   = md_busy;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [3:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] opd_i,
    input logic [7:0] breg_i,
    input logic       cy_i,
    input logic       ac_i,
    input logic [7:0] res_o,
    input logic [7:0] aux_o,
    input logic       par_o,
    input logic       ov_o,
    input logic       ac_o,
    input logic       cy_o,
    input logic       par_we_o,
    input logic       ov_we_o,
    input logic       ac_we_o,
    input logic       cy_we_o,
    input logic       aux_we_o,
    input logic       busy_o,
    input logic       done_o
);
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(start_i && !busy_o && op_i == OP_ADD)
        |-> {cy_o, res_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opd_i)})); // R1

    AST_LOGIC_PAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(start_i && !busy_o && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |-> {par_we_o, ov_we_o, ac_we_o, cy_we_o} == 4'b1000); // R3

    AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(start_i && !busy_o && op_i == OP_SWAP)
        |-> res_o == {$past(acc_i[3:0]), $past(acc_i[7:4])} && !par_we_o && !cy_we_o); // R6

    AST_MULDIV_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ov_we_o && !ac_we_o |-> cy_we_o && !cy_o && aux_we_o); // R8

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R10

    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R10

    AST_STROBE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we_o || ov_we_o || ac_we_o || cy_we_o || aux_we_o) |-> done_o); // R13

endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    import acc_alu_pkg::*;

    localparam int BPS   = 2;
    localparam int STEPS = 8 / BPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, opd_i = '0, breg_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0;
    logic [7:0] res_o, aux_o;
    logic       par_o, ov_o, ac_o, cy_o;
    logic       par_we_o, ov_we_o, ac_we_o, cy_we_o, aux_we_o, busy_o, done_o;

    always #10 clk = ~clk;

    acc_alu #(.BITS_PER_STEP(BPS)) u_acc_alu (.*);

    int vectors = 0;
    int errors  = 0;

    // reference model state, flag order {par, ov, ac, cy}
    bit [7:0] e_res, e_aux;
    bit [3:0] e_fl, e_we;
    bit       e_auxwe, e_done, e_busy;
    bit       res_dc, aux_dc, par_dc;
    int       md_left;
    bit       ign;
    string    cur_tag  = "R13";
    string    done_tag = "R10";
    // pending results
    bit [7:0] n_res, n_aux;
    bit [3:0] n_fl, n_we;
    bit       n_auxwe, n_reswe, n_div0;
    string    n_tag;

    task automatic chk(string tag, string nm, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare(string force_tag);
        string t, dt, pt;
        t  = (force_tag != "") ? force_tag : cur_tag;
        dt = (force_tag != "") ? force_tag : done_tag;
        pt = (force_tag != "") ? force_tag : "R4";
        vectors++;
        chk(dt, "done", done_o, e_done);
        chk(dt, "busy", busy_o, e_busy);
        if (!res_dc) chk(t, "res", res_o, e_res);
        if (!aux_dc) chk(t, "aux", aux_o, e_aux);
        if (!par_dc) chk(pt, "par", par_o, e_fl[3]);
        chk(t, "ov", ov_o, e_fl[2]);
        chk(t, "ac", ac_o, e_fl[1]);
        chk(t, "cy", cy_o, e_fl[0]);
        chk((force_tag != "") ? force_tag : "R13", "flag_we",
            {par_we_o, ov_we_o, ac_we_o, cy_we_o}, e_we);
        chk((force_tag != "") ? force_tag : "R13", "aux_we", aux_we_o, e_auxwe);
    endtask

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic calc(bit [3:0] op, bit [7:0] a, bit [7:0] b, bit [7:0] bb, bit c, bit acin);
        int ia, ib, ic, s, ss, t;
        bit hi_adj;
        ia = a; ib = b; ic = c;
        n_we = 0; n_auxwe = 0; n_reswe = 1; n_div0 = 0; n_aux = 0; n_fl = 0; n_res = 0;
        case (op)
            OP_ADD, OP_ADDC: begin
                if (op == OP_ADD) ic = 0;
                s  = ia + ib + ic;
                ss = sgn(ia) + sgn(ib) + ic;
                n_res = s[7:0];
                n_fl[0] = s > 255;
                n_fl[1] = (ia % 16 + ib % 16 + ic) > 15;
                n_fl[2] = (ss > 127) || (ss < -128);
                n_we = 4'b1111; n_tag = "R1";
            end
            OP_SUBB: begin
                s  = ia - ib - ic;
                ss = sgn(ia) - sgn(ib) - ic;
                n_res = s[7:0];
                n_fl[0] = s < 0;
                n_fl[1] = (ia % 16 - ib % 16 - ic) < 0;
                n_fl[2] = (ss > 127) || (ss < -128);
                n_we = 4'b1111; n_tag = "R2";
            end
            OP_AND: begin n_res = a & b; n_we = 4'b1000; n_tag = "R3"; end
            OP_OR:  begin n_res = a | b; n_we = 4'b1000; n_tag = "R3"; end
            OP_XOR: begin n_res = a ^ b; n_we = 4'b1000; n_tag = "R3"; end
            OP_RL:  begin s = ia * 2 + ia / 128; n_res = s[7:0]; n_tag = "R5"; end
            OP_RR:  begin s = ia / 2 + (ia % 2) * 128; n_res = s[7:0]; n_tag = "R5"; end
            OP_RLC: begin s = ia * 2 + ic; n_res = s[7:0]; n_fl[0] = a[7]; n_we = 4'b1001; n_tag = "R5"; end
            OP_RRC: begin s = ia / 2 + ic * 128; n_res = s[7:0]; n_fl[0] = a[0]; n_we = 4'b1001; n_tag = "R5"; end
            OP_SWAP: begin s = (ia % 16) * 16 + ia / 16; n_res = s[7:0]; n_tag = "R6"; end
            OP_XCHD: begin
                s = (ia / 16) * 16 + ib % 16; n_res = s[7:0];
                s = (ib / 16) * 16 + ia % 16; n_aux = s[7:0];
                n_auxwe = 1; n_we = 4'b1000; n_tag = "R6";
            end
            OP_DA: begin
                t = ia;
                if ((ia % 16) > 9 || acin) t = t + 6;
                hi_adj = c || (t > 255) || (((t % 256) / 16) > 9);
                t = t % 256;
                if (hi_adj) t = t + 96;
                n_res = t[7:0]; n_fl[0] = hi_adj; n_we = 4'b1001; n_tag = "R7";
            end
            OP_MUL: begin
                s = ia * bb;
                n_res = s[7:0]; s = s / 256; n_aux = s[7:0];
                n_fl[2] = (s != 0); n_we = 4'b1101; n_auxwe = 1; n_tag = "R8";
            end
            OP_DIV: begin
                if (bb == 0) begin
                    n_div0 = 1; n_fl[2] = 1;
                end else begin
                    s = ia / bb; n_res = s[7:0];
                    s = ia % bb; n_aux = s[7:0];
                end
                n_we = 4'b1101; n_auxwe = 1; n_tag = "R9";
            end
            default: begin n_reswe = 0; n_tag = "R11"; end
        endcase
        n_fl[3] = $countones(n_res) % 2;
    endtask

    task automatic apply_pending(bit [3:0] op, bit was_ign);
        e_done = 1; e_we = n_we; e_auxwe = n_auxwe;
        if (n_reswe) begin e_res = n_res; res_dc = n_div0; end
        if (n_auxwe) begin e_aux = n_aux; aux_dc = n_div0; end
        for (int i = 0; i < 4; i++) if (n_we[i]) e_fl[i] = n_fl[i];
        if (n_we[3]) par_dc = n_div0;
        cur_tag  = n_tag;
        done_tag = (was_ign || op == OP_NOP) ? "R11" : "R10";
    endtask

    bit [3:0] md_op;

    task automatic model_edge(bit s, bit [3:0] op, bit [7:0] a, b, bb, bit c, acin);
        e_done = 0; e_we = 0; e_auxwe = 0;
        if (md_left > 0) begin
            if (s) ign = 1; // R11: refused while busy
            md_left--;
            if (md_left == 0) begin
                apply_pending(md_op, ign);
                e_busy = 0; ign = 0;
            end
        end else if (s) begin
            calc(op, a, b, bb, c, acin);
            if ((op == OP_MUL || op == OP_DIV) && STEPS > 1) begin
                md_left = STEPS - 1; md_op = op; e_busy = 1; ign = 0;
            end else begin
                apply_pending(op, 0);
            end
        end
    endtask

    task automatic step(bit s, bit [3:0] op, bit [7:0] a, b, bb, bit c, acin);
        start_i = s; op_i = op; acc_i = a; opd_i = b; breg_i = bb; cy_i = c; ac_i = acin;
        @(posedge clk);
        model_edge(s, op, a, b, bb, c, acin);
        @(negedge clk);
        compare("");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, OP_NOP, 8'h00, 8'h00, 8'h00, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        // R12: reset state
        repeat (3) begin
            @(negedge clk);
            compare("R12");
        end
        rst_n = 1'b1;
        idle(2);

        // R1 add corners
        step(1, OP_ADD,  8'h7F, 8'h01, 8'h00, 0, 0);
        step(1, OP_ADD,  8'hFF, 8'h01, 8'h00, 1, 0);
        step(1, OP_ADDC, 8'h0F, 8'h00, 8'h00, 1, 0);
        step(1, OP_ADDC, 8'h80, 8'h80, 8'h00, 1, 0);
        // R2 subtract corners
        step(1, OP_SUBB, 8'h00, 8'h01, 8'h00, 0, 0);
        step(1, OP_SUBB, 8'h80, 8'h01, 8'h00, 0, 0);
        step(1, OP_SUBB, 8'h10, 8'h00, 8'h00, 1, 0);
        step(1, OP_SUBB, 8'h55, 8'h55, 8'h00, 0, 0);
        // R3 logic
        step(1, OP_AND, 8'hF3, 8'h3C, 8'h00, 1, 1);
        step(1, OP_OR,  8'h01, 8'h02, 8'h00, 0, 0);
        step(1, OP_XOR, 8'hFF, 8'h0F, 8'h00, 0, 0);
        // R5 rotates
        step(1, OP_RL,  8'h81, 8'h00, 8'h00, 0, 0);
        step(1, OP_RR,  8'h81, 8'h00, 8'h00, 1, 0);
        step(1, OP_RLC, 8'h80, 8'h00, 8'h00, 0, 0);
        step(1, OP_RRC, 8'h01, 8'h00, 8'h00, 1, 0);
        // R6 nibble operations
        step(1, OP_SWAP, 8'hA5, 8'h00, 8'h00, 0, 0);
        step(1, OP_XCHD, 8'h12, 8'h34, 8'h00, 0, 0);
        // R7 decimal adjust branches
        step(1, OP_DA, 8'h9A, 8'h00, 8'h00, 0, 0);
        step(1, OP_DA, 8'h3C, 8'h00, 8'h00, 0, 0);
        step(1, OP_DA, 8'h12, 8'h00, 8'h00, 1, 0);
        step(1, OP_DA, 8'h31, 8'h00, 8'h00, 0, 1);
        step(1, OP_DA, 8'hFA, 8'h00, 8'h00, 0, 0);
        step(1, OP_DA, 8'h45, 8'h00, 8'h00, 0, 0);
        // R8 multiply, R9 divide, R10 timing
        step(1, OP_MUL, 8'h50, 8'h00, 8'hA0, 1, 0); idle(STEPS);
        step(1, OP_MUL, 8'h03, 8'h00, 8'h04, 1, 0); idle(STEPS);
        step(1, OP_DIV, 8'd200, 8'h00, 8'd7, 1, 0); idle(STEPS);
        step(1, OP_DIV, 8'd5, 8'h00, 8'd9, 0, 0);   idle(STEPS);
        step(1, OP_DIV, 8'd77, 8'h00, 8'd0, 0, 0);  idle(STEPS);
        step(1, OP_ADD, 8'h01, 8'h02, 8'h00, 0, 0);
        // R11 requests during busy are refused, NOP leaves values
        step(1, OP_MUL, 8'hFF, 8'h00, 8'hFF, 0, 0);
        step(1, OP_ADD, 8'h11, 8'h22, 8'h00, 0, 0);
        step(1, OP_DIV, 8'h11, 8'h22, 8'h03, 0, 0);
        step(1, OP_XOR, 8'h11, 8'h22, 8'h00, 0, 0);
        step(1, OP_SUBB, 8'h09, 8'h01, 8'h00, 0, 0);
        step(1, OP_NOP, 8'hAA, 8'hBB, 8'hCC, 1, 1);
        // back-to-back single-cycle ops
        step(1, OP_RLC, 8'h40, 8'h00, 8'h00, 1, 0);
        step(1, OP_RLC, 8'h80, 8'h00, 8'h00, 0, 0);
        idle(2);

        // random mix of all codes (R1..R13)
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)),
                 8'($urandom), 8'($urandom), 8'($urandom_range(0, 7) == 0 ? 0 : $urandom),
                 1'($urandom), 1'($urandom));
        end
        idle(STEPS + 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule